// File: doc/BRIEF.md
# Programmable Event Counter Block

This block holds eight 64-bit counters that software programs and reads over a simple memory-mapped bus. Each counter gets an 8-bit event code. The code chooses either the clock itself (code 0) or one line of a bank of synchronous event strobes. A counter advances by one on each clock edge where its chosen condition is true, but only while the global run bit and that counter's own enable bit are both set.

When a counter wraps from all ones to zero, it sets its bit in a sticky overflow status register. Software clears that bit by writing one to a separate clear register. A per-counter mask, where a 1 blocks, decides which status bits drive a single level interrupt output. A configuration register stores a power-management override bit and brings it out on a pin. A read-only identifier register reports a build constant.

Bus writes take effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is registered: it appears on `bus_rdata` in the cycle after the read request and shows the state before that edge.

Top module: `evctr_unit`

## Requirements
- R1: After reset the following all read as zero: run control, counter enables, both select words, status, configuration and all counters. The mask reads 0xFF, so every interrupt is blocked. `irq` and `pm_override` are low. The identifier at 0x1cf0 reads the VERSION parameter (default 0x0C0A0102).
- R2: Counter n sits at byte address 0x1d00 + 8*n. It is written as a full 64-bit word from `bus_wdata`, and a read returns that full 64-bit value.
- R3: A counter advances only when bit 0 of the run register at 0x1c00 and bit n of the enable register at 0x1c04 are both 1. Otherwise it holds its value.
- R4: Event codes for counters 0-3 sit in the select word at 0x1c80, and codes for counters 4-7 in the select word at 0x1c84. Counter n uses bits [8*(n mod 4)+7 : 8*(n mod 4)].
- R5: Code 0 counts every clock cycle. A code k from 1 to EV_LINES-1 counts one for each cycle in which `ev_in[k]` is high. A code of EV_LINES or more never counts.
- R6: A wrap from all ones to zero sets status bit n at 0x1c78. Status is read-only, and writes to 0x1c78 change nothing.
- R7: Writing 1 to bit n of 0x1c7c clears status bit n. Bits written 0 are left unchanged.
- R8: `irq` is high exactly while some status bit n is 1 and mask bit n at 0x1c70 is 0. Setting the mask bit lowers `irq` without clearing status.
- R9: If a bus write to a counter lands in the same cycle as an increment, the counter loads the written value and does not add one.
- R10: In the configuration register at 0x0534 only bit 9 is stored; the other bits read 0. `pm_override` follows bit 9.
- R11: Reads of unmapped or misaligned addresses return 0. The identifier register ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data (32-bit registers use bits 31:0) |
| bus_rdata | output | 64 | Registered read data |
| ev_in | input | EV_LINES | Synchronous event strobes, one per code |
| irq | output | 1 | Level interrupt |
| pm_override | output | 1 | Stored power-management override bit |

## Verification
The bench preloads a counter just below all ones and runs it across the wrap. A block that compared against the wrong value, or lost the carry, would leave status clear or end at the wrong count. It collides a counter write with a running cycle count: a block that let the increment win would read back two more than the written value instead of one. It programs a code beyond the event bank, which must stay at zero rather than alias a low line. It clears status with a write to the wrong bit and with a mask change, and checks that neither of these drops a pending overflow that is still pending.

// File: rtl/evctr_pkg.sv
// Package: register offsets and packing constants shared by the counter block.
// Assumes a 16-bit byte address space and 32-bit control registers.
package evctr_pkg;
    localparam logic [15:0] OFS_RUN    = 16'h1c00;
    localparam logic [15:0] OFS_ENA    = 16'h1c04;
    localparam logic [15:0] OFS_MASK   = 16'h1c70;
    localparam logic [15:0] OFS_STAT   = 16'h1c78;
    localparam logic [15:0] OFS_CLR    = 16'h1c7c;
    localparam logic [15:0] OFS_SEL0   = 16'h1c80;
    localparam logic [15:0] OFS_ID     = 16'h1cf0;
    localparam logic [15:0] OFS_CNT0   = 16'h1d00;
    localparam logic [15:0] OFS_CFG    = 16'h0534;
    localparam int          PM_BIT     = 9;
    localparam int          CODE_W     = 8;
    localparam int          LANES      = 4;
    localparam int          CNT_STRIDE = 8;
endpackage

// File: rtl/evctr_regs.sv
// Control register file: run bit, enables, mask, event codes, config bit.
// Also decodes the clear strobe and forms read data for every 32-bit register.
// Assumes NUM <= 32 and that wr_en is already qualified with select and write.
module evctr_regs
    import evctr_pkg::*;
#(
    parameter int          NUM     = 8,
    parameter logic [31:0] VERSION = 32'h0C0A_0102
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [15:0]                 addr,
    input  logic [31:0]                 wdata,
    input  logic [NUM-1:0]              status,
    output logic                        run,
    output logic [NUM-1:0]              ena,
    output logic [NUM-1:0]              mask,
    output logic [NUM-1:0][CODE_W-1:0]  code,
    output logic [NUM-1:0]              clr,
    output logic                        pm_ovr,
    output logic                        hit,
    output logic [31:0]                 rdata
);
    localparam int NSEL = (NUM + LANES - 1) / LANES;

    // Scalar control registers written by matching address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            ena    <= '0;
            mask   <= '1;
            pm_ovr <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFS_RUN:  run    <= wdata[0];
                OFS_ENA:  ena    <= wdata[NUM-1:0];
                OFS_MASK: mask   <= wdata[NUM-1:0];
                OFS_CFG:  pm_ovr <= wdata[PM_BIT];
                default:  ;
            endcase
        end
    end

    // Event code lanes, each updated from its select word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < NUM; n++) begin
                if (addr == OFS_SEL0 + 16'(4 * (n / LANES)))
                    code[n] <= wdata[CODE_W*(n % LANES) +: CODE_W];
            end
        end
    end

    // One-cycle clear pulse for the status bits written as 1.
    assign clr = (wr_en && addr == OFS_CLR) ? wdata[NUM-1:0] : '0;

    // Read data and hit flag for the control registers.
    always_comb begin
        rdata = '0;
        hit   = 1'b1;
        case (addr)
            OFS_RUN:  rdata[0]       = run;
            OFS_ENA:  rdata          = 32'(ena);
            OFS_MASK: rdata          = 32'(mask);
            OFS_STAT: rdata          = 32'(status);
            OFS_ID:   rdata          = VERSION;
            OFS_CFG:  rdata[PM_BIT]  = pm_ovr;
            default:  hit            = 1'b0;
        endcase
        for (int w = 0; w < NSEL; w++) begin
            if (addr == OFS_SEL0 + 16'(4 * w)) begin
                hit = 1'b1;
                for (int n = 0; n < NUM; n++) begin
                    if (n / LANES == w)
                        rdata[CODE_W*(n % LANES) +: CODE_W] = code[n];
                end
            end
        end
    end
endmodule

// File: rtl/evctr_counter.sv
// One event counter: picks its condition from the code, counts when gated,
// loads bus writes with priority, and flags the wrap from all ones.
// Assumes EV_LINES <= 2**CODE_W; line 0 is unused since code 0 means cycles.
module evctr_counter
    import evctr_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int EV_LINES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                ena,
    input  logic [CODE_W-1:0]   code,
    input  logic [EV_LINES-1:0] ev_in,
    input  logic                wr_en,
    input  logic [CNT_W-1:0]    wr_val,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                ovf
);
    localparam int NCODES = 1 << CODE_W;

    logic [NCODES-1:0] ev_wide;
    logic              hit_ev;
    logic              inc;

    // Widen the strobe bank so unused codes select a constant zero.
    always_comb begin
        ev_wide               = '0;
        ev_wide[EV_LINES-1:0] = ev_in;
    end

    assign hit_ev = (code == '0) ? 1'b1 : ev_wide[code];
    assign inc    = run & ena & hit_ev;
    assign ovf    = inc & ~wr_en & (&cnt_q);

    // Count register: bus write beats increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= wr_val;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/evctr_irq.sv
// Sticky overflow status with write-one-to-clear and a blocking mask.
// A new overflow in the same cycle as its clear keeps the bit set.
module evctr_irq #(
    parameter int NUM = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] ovf,
    input  logic [NUM-1:0] clr,
    input  logic [NUM-1:0] mask,
    output logic [NUM-1:0] status,
    output logic           irq
);
    // Status bits: set by wrap, cleared by strobe, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr) | ovf;
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/evctr_unit.sv
// Top of the event counter block: bus decode, counter array, status and
// interrupt, registered read data. Assumes NUM_CTR <= 32 and CNT_W <= 64.
module evctr_unit
    import evctr_pkg::*;
#(
    parameter int          NUM_CTR  = 8,
    parameter int          CNT_W    = 64,
    parameter int          EV_LINES = 16,
    parameter logic [31:0] VERSION  = 32'h0C0A_0102
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [15:0]         bus_addr,
    input  logic [63:0]         bus_wdata,
    output logic [63:0]         bus_rdata,
    input  logic [EV_LINES-1:0] ev_in,
    output logic                irq,
    output logic                pm_override
);
    logic                             wr_en;
    logic                             run;
    logic [NUM_CTR-1:0]               ena;
    logic [NUM_CTR-1:0]               mask;
    logic [NUM_CTR-1:0][CODE_W-1:0]   code;
    logic [NUM_CTR-1:0]               clr;
    logic [NUM_CTR-1:0]               status;
    logic [NUM_CTR-1:0]               ovf;
    logic [NUM_CTR-1:0]               cnt_wr;
    logic [NUM_CTR-1:0]               cnt_hit;
    logic [NUM_CTR-1:0][CNT_W-1:0]    cnt_q;
    logic                             ctl_hit;
    logic [31:0]                      ctl_rdata;
    logic [63:0]                      rd_mux;

    assign wr_en = bus_sel & bus_wr;

    evctr_regs #(.NUM(NUM_CTR), .VERSION(VERSION)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata[31:0]),
        .status (status),
        .run    (run),
        .ena    (ena),
        .mask   (mask),
        .code   (code),
        .clr    (clr),
        .pm_ovr (pm_override),
        .hit    (ctl_hit),
        .rdata  (ctl_rdata)
    );

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        assign cnt_hit[n] = (bus_addr == OFS_CNT0 + 16'(CNT_STRIDE * n));
        assign cnt_wr[n]  = wr_en & cnt_hit[n];

        evctr_counter #(.CNT_W(CNT_W), .EV_LINES(EV_LINES)) i_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .ena    (ena[n]),
            .code   (code[n]),
            .ev_in  (ev_in),
            .wr_en  (cnt_wr[n]),
            .wr_val (bus_wdata[CNT_W-1:0]),
            .cnt_q  (cnt_q[n]),
            .ovf    (ovf[n])
        );
    end

    evctr_irq #(.NUM(NUM_CTR)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf    (ovf),
        .clr    (clr),
        .mask   (mask),
        .status (status),
        .irq    (irq)
    );

    // Read mux over control registers and counters; unmapped gives zero.
    always_comb begin
        rd_mux = '0;
        if (ctl_hit)
            rd_mux = 64'(ctl_rdata);
        for (int n = 0; n < NUM_CTR; n++) begin
            if (cnt_hit[n])
                rd_mux[CNT_W-1:0] = cnt_q[n];
        end
    end

    // Registered read data, updated only on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_sel && !bus_wr)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/evctr_checker.sv
// Checker for the event counter block, attached to every evctr_unit by bind.
module evctr_checker
    import evctr_pkg::*;
#(
    parameter int NUM   = 8,
    parameter int CNT_W = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [15:0]               bus_addr,
    input logic                      run,
    input logic [NUM-1:0]            mask,
    input logic [NUM-1:0]            status,
    input logic [NUM-1:0]            ovf,
    input logic [NUM-1:0][CNT_W-1:0] cnt_q,
    input logic                      irq
);
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status == '0 && !irq));

    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(bus_sel && bus_wr)) |=> $stable(cnt_q));

    p_wrap_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf) |=> ((status & $past(ovf)) == $past(ovf)));

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == OFS_CLR)
            |=> ((status & $past(status)) == $past(status)));

    p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);

    p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|status));
endmodule

bind evctr_unit evctr_checker #(.NUM(NUM_CTR), .CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .run      (run),
    .mask     (mask),
    .status   (status),
    .ovf      (ovf),
    .cnt_q    (cnt_q),
    .irq      (irq)
);

// File: tb/test_evctr_unit.sv
// Directed bench for evctr_unit: one task per scenario, each checking itself.
module test_evctr_unit;
    localparam int EVL = 16;
    localparam logic [31:0] VER = 32'h0C0A_0102;
    localparam logic [15:0] A_RUN = 16'h1c00, A_ENA = 16'h1c04, A_MASK = 16'h1c70,
                            A_STAT = 16'h1c78, A_CLR = 16'h1c7c, A_SEL0 = 16'h1c80,
                            A_SEL1 = 16'h1c84, A_ID = 16'h1cf0, A_CFG = 16'h0534;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_sel = 1'b0;
    logic           bus_wr = 1'b0;
    logic [15:0]    bus_addr = '0;
    logic [63:0]    bus_wdata = '0;
    logic [63:0]    bus_rdata;
    logic [EVL-1:0] ev_in = '0;
    logic           irq;
    logic           pm_override;
    int             total = 0;
    int             bad = 0;
    logic [63:0]    rv;

    always #4 clk = ~clk;

    evctr_unit #(.EV_LINES(EVL), .VERSION(VER)) i_evctr_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_in(ev_in), .irq(irq), .pm_override(pm_override)
    );

    function automatic logic [15:0] cnt_addr(input int n);
        return 16'h1d00 + 16'(8 * n);
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [EVL-1:0] v);
        ev_in = v;
        @(negedge clk);
        ev_in = '0;
    endtask

    task automatic t_reset;
        rd(A_RUN, rv);  check("R1 run", rv, 64'h0);
        rd(A_ENA, rv);  check("R1 enables", rv, 64'h0);
        rd(A_MASK, rv); check("R1 mask", rv, 64'hFF);
        rd(A_STAT, rv); check("R1 status", rv, 64'h0);
        rd(A_SEL1, rv); check("R1 select1", rv, 64'h0);
        rd(A_CFG, rv);  check("R1 config", rv, 64'h0);
        rd(A_ID, rv);   check("R1 identifier", rv, 64'(VER));
        rd(cnt_addr(7), rv); check("R1 counter7", rv, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
        check("R1 pm_override", 64'(pm_override), 64'h0);
    endtask

    task automatic t_wide_rw;
        wr(cnt_addr(3), 64'h0123_4567_89AB_CDEF);
        rd(cnt_addr(3), rv); check("R2 counter3 64-bit", rv, 64'h0123_4567_89AB_CDEF);
        rd(cnt_addr(2), rv); check("R2 neighbour untouched", rv, 64'h0);
    endtask

    task automatic t_cycles;
        wr(A_SEL0, 64'h0);
        wr(A_ENA, 64'h01);
        wr(A_RUN, 64'h1);
        repeat (10) @(negedge clk);
        wr(A_RUN, 64'h0);
        rd(cnt_addr(0), rv); check("R5 code0 cycle count", rv, 64'd11);
    endtask

    task automatic t_events;
        wr(A_SEL0, 64'h0005_0300);
        wr(A_SEL1, 64'h0000_0320);
        rd(A_SEL0, rv); check("R4 select0 readback", rv, 64'h0005_0300);
        wr(A_ENA, 64'h26);
        wr(A_RUN, 64'h1);
        pulse(16'h0008); pulse(16'h0008);
        pulse(16'h0028); pulse(16'h0028);
        pulse(16'h0080);
        wr(A_RUN, 64'h0);
        rd(cnt_addr(1), rv); check("R5 code3 lane1", rv, 64'd4);
        rd(cnt_addr(2), rv); check("R5 code5 lane2", rv, 64'd2);
        rd(cnt_addr(5), rv); check("R4 code3 in select1 lane1", rv, 64'd4);
        rd(cnt_addr(0), rv); check("R3 disabled counter holds", rv, 64'd11);
        rd(cnt_addr(3), rv); check("R3 disabled counter3 holds", rv, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_global_off;
        pulse(16'h0008); pulse(16'h0008); pulse(16'h0008);
        rd(cnt_addr(1), rv); check("R3 run bit clear blocks", rv, 64'd4);
    endtask

    task automatic t_out_of_range;
        wr(A_ENA, 64'h10);
        wr(A_RUN, 64'h1);
        pulse(16'hFFFF); pulse(16'hFFFF); pulse(16'hFFFF);
        wr(A_RUN, 64'h0);
        rd(cnt_addr(4), rv); check("R5 code beyond bank", rv, 64'h0);
    endtask

    task automatic t_wrap_irq;
        wr(cnt_addr(6), 64'hFFFF_FFFF_FFFF_FFFE);
        wr(A_ENA, 64'h40);
        wr(A_MASK, 64'hBF);
        wr(A_RUN, 64'h1);
        repeat (3) @(negedge clk);
        wr(A_RUN, 64'h0);
        rd(cnt_addr(6), rv); check("R6 wrapped value", rv, 64'd2);
        rd(A_STAT, rv); check("R6 status after wrap", rv, 64'h40);
        check("R8 irq unmasked", 64'(irq), 64'h1);
        wr(A_MASK, 64'hFF);
        check("R8 irq masked", 64'(irq), 64'h0);
        rd(A_STAT, rv); check("R8 mask keeps status", rv, 64'h40);
        wr(A_MASK, 64'hBF);
        check("R8 irq back", 64'(irq), 64'h1);
        wr(A_CLR, 64'h01);
        rd(A_STAT, rv); check("R7 other bit clear no effect", rv, 64'h40);
        wr(A_STAT, 64'hFF);
        rd(A_STAT, rv); check("R6 status write ignored", rv, 64'h40);
        wr(A_CLR, 64'h40);
        rd(A_STAT, rv); check("R7 clear bit6", rv, 64'h0);
        check("R8 irq after clear", 64'(irq), 64'h0);
    endtask

    task automatic t_masked_wrap;
        wr(A_SEL1, 64'h0100_0320);
        wr(cnt_addr(7), 64'hFFFF_FFFF_FFFF_FFFF);
        wr(A_ENA, 64'h80);
        wr(A_MASK, 64'hFF);
        wr(A_RUN, 64'h1);
        pulse(16'h0002);
        wr(A_RUN, 64'h0);
        rd(A_STAT, rv); check("R6 masked wrap sets status", rv, 64'h80);
        check("R8 masked wrap no irq", 64'(irq), 64'h0);
        wr(A_MASK, 64'h7F);
        check("R8 unmask raises irq", 64'(irq), 64'h1);
        wr(A_CLR, 64'h80);
        check("R7 clear drops irq", 64'(irq), 64'h0);
    endtask

    task automatic t_collision;
        wr(A_ENA, 64'h01);
        wr(A_RUN, 64'h1);
        wr(cnt_addr(0), 64'd100);
        wr(A_RUN, 64'h0);
        rd(cnt_addr(0), rv); check("R9 write beats increment", rv, 64'd101);
    endtask

    task automatic t_cfg_misc;
        wr(A_CFG, 64'hFFFF_FFFF);
        rd(A_CFG, rv); check("R10 only bit9 stored", rv, 64'h200);
        check("R10 pm_override high", 64'(pm_override), 64'h1);
        wr(A_CFG, 64'h0);
        check("R10 pm_override low", 64'(pm_override), 64'h0);
        wr(A_ID, 64'h1234_5678);
        rd(A_ID, rv); check("R11 identifier read-only", rv, 64'(VER));
        rd(16'h1000, rv); check("R11 unmapped read", rv, 64'h0);
        rd(16'h1d04, rv); check("R11 misaligned counter read", rv, 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1 got=hung exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_wide_rw;
        t_cycles;
        t_events;
        t_global_off;
        t_out_of_range;
        t_wrap_irq;
        t_masked_wrap;
        t_collision;
        t_cfg_misc;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule